// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This block is the combinational arithmetic/logic stage of a small microcontroller datapath. Each cycle it takes a destination operand, a second operand that is either a register value or an 8-bit constant, the current arithmetic flags, and an operation code. It returns the 8-bit result, six updated flags and a write enable. The write enable tells the register file whether the result replaces the destination operand.

All arithmetic goes through one shared adder/subtractor. Subtraction is done by inverting the second operand and the carry-in. The flag stage then derives the half carry, overflow, negative, zero, sign and carry bits. Some operations keep some of the incoming flags unchanged, and the carry bit means a borrow on every subtracting operation. The block holds no state and has no clock, so its outputs follow its inputs within the same cycle.

Top module: `alu8_core`

## Requirements
- R1: When `use_imm` is 1, `imm_k` is used as the second operand in place of `src_r`; when it is 0, `src_r` is used.
- R2: ADD (op 0) gives (dst+src) mod 256. ADC (op 1) also adds the incoming carry `flags_in[0]`. The carry flag (flag bit 0) is the carry out of bit 7, and the half-carry flag (flag bit 5) is the carry from bit 3 into bit 4.
- R3: On every operation except SER, N (bit 2) is result bit 7 and Z (bit 1) is 1 exactly when the result is 0x00. S (bit 4) is N XOR V, where V (bit 3) is set only when the carry into bit 7 differs from the carry out of bit 7, so adding operands of opposite sign never sets V.
- R4: SUB (op 2) gives dst-src. SBC (op 3) also subtracts the incoming carry as a borrow. C is 1 when src plus borrow-in exceeds dst, unsigned. H is 1 when the low nibble of src plus borrow-in exceeds the low nibble of dst. For example, 0x3B-0x3B gives 0x00 with only Z set, and 0x3B-0x15 gives 0x26 with all flags clear.
- R5: CMP (op 4) and CPC (op 5) give the same result and flags as SUB and SBC, but `wr_en` is 0. `wr_en` is 1 for all other operations except TST.
- R6: AND (op 6), OR (op 7), XOR (op 8) and TST (op 15; result equals dst, `wr_en` 0) clear V and pass H and C through from `flags_in` unchanged.
- R7: COM (op 9) gives the bitwise inverse of dst, sets C to 1, clears V and keeps H.
- R8: NEG (op 10) gives 0-dst. C is set when dst is non-zero, V is set when the result is 0x80, and H is the borrow out of the low nibble.
- R9: INC (op 11) and DEC (op 12) add or subtract one and keep H and C. V is set only when the result is 0x80 after INC or 0x7F after DEC.
- R10: CLR (op 13) gives 0x00 with Z=1, N=V=S=0, and keeps H and C. SER (op 14) gives 0xFF and passes all six flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_a | input | 8 | Destination operand, first operand of every operation |
| src_r | input | 8 | Register source operand |
| imm_k | input | 8 | Constant source operand |
| use_imm | input | 1 | Selects `imm_k` instead of `src_r` |
| op_sel | input | 4 | Operation code (encodings in R2 to R10) |
| flags_in | input | 6 | Current flags: bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H |
| result | output | 8 | Operation result |
| flags_out | output | 6 | Updated flags, same bit order as `flags_in` |
| wr_en | output | 1 | Result is written back to the destination |

## Verification
Immediate assertions inside the top module are evaluated on every input change. They check that the adding operations give the exact 9-bit sum and carry, and that the carry on subtracting operations equals the unsigned borrow. They also check that V is only ever set for same-sign additions, that Z tracks a zero result, that compares never write back, and that the logic operations keep the incoming carry. Only the bench scenarios can show the rest: the exact values of the documented subtraction cases, the special overflow points of increment, decrement and negate, the flags kept by clear and set-all, and the choice between the immediate and the register operand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW   = 8;
    localparam int NFLG = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_CMP = 4'd4,  OP_CPC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
        OP_XOR = 4'd8,  OP_COM = 4'd9,  OP_NEG = 4'd10, OP_INC = 4'd11,
        OP_DEC = 4'd12, OP_CLR = 4'd13, OP_SER = 4'd14, OP_TST = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_INV = 2'd3
    } logic_fn_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    logic [W-1:0]  bx;
    logic          ci;
    logic [W-1:0]  low_sum;
    logic [HB:0]   nib_sum;
    logic          c_msb_in;
    logic          c_msb_out;

    // subtraction: a + ~b + ~borrow, carries then read as inverted borrows
    assign bx = sub ? ~b : b;
    assign ci = sub ? ~cin : cin;

    assign low_sum  = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
    assign c_msb_in = low_sum[W-1];
    assign c_msb_out = (a[W-1] & bx[W-1]) | (a[W-1] & c_msb_in) | (bx[W-1] & c_msb_in);
    assign sum      = {a[W-1] ^ bx[W-1] ^ c_msb_in, low_sum[W-2:0]};

    assign nib_sum  = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};

    assign c_out = sub ? ~c_msb_out : c_msb_out;
    assign h_out = sub ? ~nib_sum[HB] : nib_sum[HB];
    assign v_out = c_msb_in ^ c_msb_out;
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_INV:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    input  logic         v_in,
    output logic         n_out,
    output logic         z_out,
    output logic         s_out
);
    assign n_out = res[W-1];
    assign z_out = (res == '0);
    assign s_out = res[W-1] ^ v_in;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] dst_a,
    input  logic [7:0] src_r,
    input  logic [7:0] imm_k,
    input  logic       use_imm,
    input  logic [3:0] op_sel,
    input  logic [5:0] flags_in,
    output logic [7:0] result,
    output logic [5:0] flags_out,
    output logic       wr_en
);
    alu_op_e          op;
    logic [DW-1:0]    opnd_b;
    logic [DW-1:0]    as_a, as_b, as_sum;
    logic             as_cin, as_sub, as_c, as_h, as_v;
    logic [DW-1:0]    lg_y;
    logic_fn_e        lg_fn;
    logic [DW-1:0]    res_mux;
    logic             v_sel;
    logic             fl_n, fl_z, fl_s;
    logic             cin_q;

    assign op     = alu_op_e'(op_sel);
    assign opnd_b = use_imm ? imm_k : src_r;
    assign cin_q  = flags_in[FC];

    // operand steering for the shared adder
    always_comb begin
        as_a   = dst_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADD: ;
            OP_ADC: as_cin = cin_q;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = cin_q; end
            OP_NEG: begin as_a = '0; as_b = dst_a; as_sub = 1'b1; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_COM:  lg_fn = LG_INV;
            default: lg_fn = LG_AND;
        endcase
    end

    alu8_addsub #(.W(DW), .HB(DW/2)) u_as (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_logic #(.W(DW)) u_lg (
        .a(dst_a), .b((op == OP_TST) ? dst_a : opnd_b), .fn(lg_fn), .y(lg_y)
    );

    // result and overflow selection
    always_comb begin
        res_mux = as_sum;
        v_sel   = as_v;
        unique case (op)
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_TST: begin res_mux = lg_y; v_sel = 1'b0; end
            OP_CLR: begin res_mux = '0; v_sel = 1'b0; end
            OP_SER: begin res_mux = '1; v_sel = flags_in[FV]; end
            default: ;
        endcase
    end

    alu8_flags #(.W(DW)) u_fl (
        .res(res_mux), .v_in(v_sel), .n_out(fl_n), .z_out(fl_z), .s_out(fl_s)
    );

    // flag assembly and write enable
    always_comb begin
        flags_out     = flags_in;
        wr_en         = 1'b1;
        result        = res_mux;
        flags_out[FN] = fl_n;
        flags_out[FZ] = fl_z;
        flags_out[FS] = fl_s;
        flags_out[FV] = v_sel;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                flags_out[FC] = as_c;
                flags_out[FH] = as_h;
            end
            OP_CMP, OP_CPC: begin
                flags_out[FC] = as_c;
                flags_out[FH] = as_h;
                wr_en         = 1'b0;
            end
            OP_COM: flags_out[FC] = 1'b1;
            OP_TST: wr_en = 1'b0;
            OP_SER: flags_out = flags_in;
            default: ;
        endcase
    end

    // checks on the assembled outputs
    always_comb begin
        if (op == OP_ADD || op == OP_ADC) begin
            assert_add_sum_R2: assert ({flags_out[FC], result} ==
                ({1'b0, dst_a} + {1'b0, opnd_b} + {8'b0, (op == OP_ADC) & cin_q}));
            if (flags_out[FV]) begin
                assert_overflow_sign_R3: assert (dst_a[7] == opnd_b[7] && result[7] != dst_a[7]);
            end
        end
        if (op == OP_SUB || op == OP_SBC || op == OP_CMP || op == OP_CPC) begin
            assert_sub_borrow_R4: assert (flags_out[FC] ==
                (({1'b0, opnd_b} + {8'b0, (op == OP_SBC || op == OP_CPC) & cin_q}) > {1'b0, dst_a}));
        end
        if (op == OP_CMP || op == OP_CPC) begin
            assert_cmp_nowrite_R5: assert (!wr_en);
        end
        if (op != OP_SER) begin
            assert_zero_flag_R3: assert (flags_out[FZ] == (result == 8'h00));
        end
        if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TST) begin
            assert_keep_carry_R6: assert (flags_out[FC] == flags_in[FC] && !flags_out[FV]);
        end
    end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] dst_a, src_r, imm_k;
    logic       use_imm;
    logic [3:0] op_sel;
    logic [5:0] flags_in;
    logic [7:0] result;
    logic [5:0] flags_out;
    logic       wr_en;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_core u0 (
        .dst_a(dst_a), .src_r(src_r), .imm_k(imm_k), .use_imm(use_imm),
        .op_sel(op_sel), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .wr_en(wr_en)
    );

    // expected {wr_en, flags, result} from the requirement text
    function automatic logic [14:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [5:0] fi);
        logic [7:0] r;
        logic [5:0] f;
        logic       w;
        int         c, t;
        f = fi; w = 1'b1; r = 8'h00;
        case (op)
            4'd0, 4'd1: begin
                c = (op == 4'd1) ? int'(fi[0]) : 0;
                t = int'(a) + int'(b) + c;
                r = t[7:0];
                f[0] = (t > 255);
                f[5] = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
                f[3] = (a[7] == b[7]) && (r[7] != a[7]);
            end
            4'd2, 4'd3, 4'd4, 4'd5: begin
                c = (op == 4'd3 || op == 4'd5) ? int'(fi[0]) : 0;
                t = int'(a) - int'(b) - c;
                r = t[7:0];
                f[0] = (int'(b) + c) > int'(a);
                f[5] = (int'(b[3:0]) + c) > int'(a[3:0]);
                f[3] = (a[7] != b[7]) && (r[7] != a[7]);
                w = (op < 4'd4);
            end
            4'd6: begin r = a & b; f[3] = 1'b0; end
            4'd7: begin r = a | b; f[3] = 1'b0; end
            4'd8: begin r = a ^ b; f[3] = 1'b0; end
            4'd9: begin r = ~a; f[3] = 1'b0; f[0] = 1'b1; end
            4'd10: begin
                t = 0 - int'(a);
                r = t[7:0];
                f[0] = (a != 0);
                f[5] = (a[3:0] != 0);
                f[3] = (r == 8'h80);
            end
            4'd11: begin r = a + 8'd1; f[3] = (r == 8'h80); end
            4'd12: begin r = a - 8'd1; f[3] = (r == 8'h7F); end
            4'd13: begin r = 8'h00; f[3] = 1'b0; end
            4'd14: r = 8'hFF;
            default: begin r = a; f[3] = 1'b0; w = 1'b0; end
        endcase
        if (op != 4'd14) begin
            f[2] = r[7];
            f[1] = (r == 0);
            f[4] = f[2] ^ f[3];
        end
        return {w, f, r};
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] k, input logic ui, input logic [5:0] fi);
        @(negedge clk);
        op_sel = op; dst_a = a; src_r = b; imm_k = k; use_imm = ui; flags_in = fi;
        #5;
    endtask

    task automatic check(input string req, input logic [14:0] exp);
        checks++;
        if ({wr_en, flags_out, result} !== exp) begin
            errors++;
            $display("FAIL %s: got wr=%0b flags=%06b res=%02h, expected wr=%0b flags=%06b res=%02h",
                     req, wr_en, flags_out, result, exp[14], exp[13:8], exp[7:0]);
        end
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [5:0] fi);
        drive(op, a, b, 8'h00, 1'b0, fi);
        check(req, model(op, a, b, fi));
    endtask

    task automatic t_idle;
        drive(4'd0, 8'h00, 8'h00, 8'h00, 1'b0, 6'b0);
        check("R3 idle zero add", {1'b1, 6'b000010, 8'h00});
    endtask

    task automatic t_add;
        drive(4'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 6'b0);
        check("R2 R3 add overflow", {1'b1, 6'b101100, 8'h80});
        run("R2 add carry", 4'd0, 8'hF0, 8'h20, 6'b0);
        run("R2 adc carry in", 4'd1, 8'h0F, 8'h00, 6'b000001);
        run("R3 neg+neg overflow", 4'd0, 8'h80, 8'hFF, 6'b0);
        run("R3 opposite signs", 4'd0, 8'h7F, 8'h80, 6'b0);
    endtask

    task automatic t_sub;
        drive(4'd2, 8'h3B, 8'h3B, 8'h00, 1'b0, 6'b111111);
        check("R4 3B-3B", {1'b1, 6'b000010, 8'h00});
        drive(4'd2, 8'h3B, 8'h15, 8'h00, 1'b0, 6'b0);
        check("R4 3B-15", {1'b1, 6'b000000, 8'h26});
        foreach (pairs_a[i]) begin
            run("R4 sub table", 4'd2, pairs_a[i], pairs_b[i], 6'b0);
        end
        run("R4 sbc borrow", 4'd3, 8'h10, 8'h0F, 6'b000001);
        run("R4 sbc equal borrow", 4'd3, 8'h05, 8'h05, 6'b000001);
    endtask

    logic [7:0] pairs_a [7] = '{8'h15, 8'hF9, 8'hF6, 8'h15, 8'hF6, 8'h68, 8'hA5};
    logic [7:0] pairs_b [7] = '{8'h3B, 8'hF6, 8'hF9, 8'hF6, 8'h15, 8'hA5, 8'h68};

    task automatic t_cmp;
        run("R5 cmp", 4'd4, 8'h20, 8'h30, 6'b0);
        run("R5 cpc", 4'd5, 8'h30, 8'h30, 6'b000001);
        drive(4'd4, 8'h44, 8'h00, 8'h44, 1'b1, 6'b0);
        check("R5 cmp no write", {1'b0, 6'b000010, 8'h00});
    endtask

    task automatic t_imm;
        drive(4'd2, 8'h50, 8'h01, 8'h10, 1'b1, 6'b0);
        check("R1 immediate used", model(4'd2, 8'h50, 8'h10, 6'b0));
        drive(4'd7, 8'h01, 8'h80, 8'h02, 1'b0, 6'b0);
        check("R1 register used", {1'b1, 6'b010100, 8'h81});
    endtask

    task automatic t_logic;
        run("R6 and keep HC", 4'd6, 8'hF0, 8'h3C, 6'b101001);
        run("R6 or", 4'd7, 8'h80, 8'h01, 6'b001000);
        run("R6 xor zero", 4'd8, 8'h5A, 8'h5A, 6'b100001);
        drive(4'd15, 8'h80, 8'h00, 8'h00, 1'b0, 6'b101001);
        check("R6 tst", {1'b0, 6'b110101, 8'h80});
    endtask

    task automatic t_com_neg;
        drive(4'd9, 8'h0F, 8'h00, 8'h00, 1'b0, 6'b101000);
        check("R7 com", {1'b1, 6'b110101, 8'hF0});
        run("R8 neg 0x80", 4'd10, 8'h80, 8'h00, 6'b0);
        run("R8 neg zero", 4'd10, 8'h00, 8'h00, 6'b111111);
        run("R8 neg one", 4'd10, 8'h01, 8'h00, 6'b0);
    endtask

    task automatic t_incdec;
        drive(4'd11, 8'h7F, 8'h00, 8'h00, 1'b0, 6'b100001);
        check("R9 inc 7F", {1'b1, 6'b101101, 8'h80});
        run("R9 inc FF", 4'd11, 8'hFF, 8'h00, 6'b0);
        drive(4'd12, 8'h80, 8'h00, 8'h00, 1'b0, 6'b0);
        check("R9 dec 80", {1'b1, 6'b011000, 8'h7F});
        run("R9 dec 00", 4'd12, 8'h00, 8'h00, 6'b100001);
    endtask

    task automatic t_clr_ser;
        drive(4'd13, 8'hAA, 8'h00, 8'h00, 1'b0, 6'b111101);
        check("R10 clr", {1'b1, 6'b100011, 8'h00});
        drive(4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 6'b010110);
        check("R10 ser", {1'b1, 6'b010110, 8'hFF});
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 256; i += 7) begin
            for (int j = 0; j < 256; j += 13) begin
                for (int o = 0; o < 16; o++) begin
                    run("R2 R3 R4 sweep", 4'(o), 8'(i), 8'(j), 6'((i + j + o) % 64));
                end
            end
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        dst_a = 0; src_r = 0; imm_k = 0; use_imm = 0; op_sel = 0; flags_in = 0;
        repeat (2) @(posedge clk);
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_imm();
        t_logic();
        t_com_neg();
        t_incdec();
        t_clr_ser();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule